// File: doc/BRIEF.md
# Vectored Interrupt Acknowledge Unit

This block watches three active-low interrupt priority pins and turns a qualifying request into an interrupt acknowledge bus cycle. The pins carry one of eight levels. Level 0 means no request. A level goes forward only after it has been synchronised and seen steady. It is then compared against a programmable current mask. When the request wins, the unit runs a read cycle on the external bus. The serviced level appears on the three lowest word-address bits and every other address bit is driven high. The responding device places an 8-bit vector number on the low data byte.

The cycle uses the same transfer-acknowledge handshake as any read, and whole-clock wait states are added until the acknowledge arrives. When the vector is captured, the mask is raised to the accepted level. The level and the vector are handed to the core with a one-cycle valid pulse. A further acknowledge cycle is held off until the core reports that it has consumed the vector.

Top module: `intack_unit`

## Requirements
- R1: After reset the address strobe and both data strobes are high (inactive), `irq_valid` is 0 and `mask_q` reads 7.
- R2: A steady level L starts an acknowledge cycle only when L is greater than `mask_q`, or when L equals 7 (always accepted). Level 0 never starts a cycle.
- R3: While the address strobe is low, `bus_addr[2:0]` equals the serviced level and every bit of `bus_addr` above bit 2 is 1.
- R4: The acknowledge cycle is a byte read on the lower lane. `rd_wr` is 1, `low_strobe_n` is 0 and `upper_strobe_n` is 1 while the address strobe is low. The vector is taken from `bus_rdata[7:0]` only.
- R5: The strobes stay low until `xfer_ack_n` is sampled low at a rising edge. With N cycles of delayed acknowledge, the strobes are low for N+1 cycles.
- R6: A priority code that is present on the pins for only one clock cycle is ignored.
- R7: When the vector is captured, `irq_valid` is high for exactly one cycle, with `irq_level` and `irq_vector` valid. In that same cycle `mask_q` already equals the accepted level.
- R8: After a valid pulse, no new acknowledge cycle begins until `irq_taken` has been high for a cycle.
- R9: A cycle with `mask_wr` high loads `mask_wdata` into `mask_q` at that rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ipl_n | input | 3 | Active-low interrupt priority code |
| mask_wr | input | 1 | Mask write enable |
| mask_wdata | input | 3 | New mask value |
| mask_q | output | 3 | Current mask |
| bus_addr | output | ADDR_W (23) | Word address; bit 0 is the lowest word-address line |
| addr_strobe_n | output | 1 | Address strobe, active low |
| upper_strobe_n | output | 1 | Upper-byte data strobe, active low |
| low_strobe_n | output | 1 | Lower-byte data strobe, active low |
| rd_wr | output | 1 | 1 = read |
| xfer_ack_n | input | 1 | Transfer acknowledge, active low |
| bus_rdata | input | DATA_W (16) | Read data |
| irq_valid | output | 1 | One-cycle pulse: level and vector valid |
| irq_level | output | 3 | Accepted level |
| irq_vector | output | 8 | Captured vector number |
| irq_taken | input | 1 | Core has consumed the vector |

## Verification
The timing of each result is counted from the edge that captures it:

- **Pin change to address strobe:** a pin change reaches the strobe no earlier than five rising edges later. This covers two synchroniser flops, one stability compare, the level register and the address phase.
- **Strobe length:** the strobe then stays low for one cycle plus the number of acknowledge-delay cycles.
- **Valid pulse:** the valid pulse follows the capturing edge by one cycle.

The bench drives inputs and its bus responder on falling edges, and samples every output on falling edges. It polls for the valid pulse within a bounded window and then checks, on the very next falling edge, that the pulse has dropped. Rejections are checked by counting strobe-low cycles across a window well past the five-edge latency.

// File: rtl/intack_pkg.sv
package intack_pkg;
  localparam int LVL_W = 3;
  localparam logic [LVL_W-1:0] LVL_NMI = '1;

  typedef enum logic [1:0] {ST_IDLE, ST_ADDR, ST_WAIT, ST_DONE} ack_state_e;

  // Acceptance rule: above the mask, or the top level which cannot be masked.
  function automatic logic lvl_wins(input logic [LVL_W-1:0] lvl,
                                    input logic [LVL_W-1:0] mask);
    return (lvl == LVL_NMI) || (lvl > mask);
  endfunction
endpackage

// File: rtl/ipl_sync.sv
module ipl_sync #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] ipl_n,
  output logic [W-1:0] lvl
);
  logic [W-1:0] s1, s2, s3;
  logic         steady;

  assign steady = (s2 == s3);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1  <= '1;
      s2  <= '1;
      s3  <= '1;
      lvl <= '0;
    end else begin
      s1 <= ipl_n;
      s2 <= s1;
      s3 <= s2;
      if (steady) lvl <= ~s2;
    end
  end

  AST_FILTER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !steady |=> $stable(lvl)); // R6
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import intack_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] lvl,
  input  logic             mask_wr,
  input  logic [LVL_W-1:0] mask_wdata,
  input  logic             raise,
  input  logic [LVL_W-1:0] raise_lvl,
  output logic [LVL_W-1:0] mask_q,
  output logic             req
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '1;
    else if (raise)   mask_q <= raise_lvl;
    else if (mask_wr) mask_q <= mask_wdata;
  end

  assign req = lvl_wins(lvl, mask_q);

  AST_MASK_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    raise |=> (mask_q == $past(raise_lvl))); // R7
  AST_MASK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_wr && !raise) |=> (mask_q == $past(mask_wdata))); // R9
endmodule

// File: rtl/ack_cycle.sv
module ack_cycle
  import intack_pkg::*;
#(
  parameter int ADDR_W = 23,
  parameter int VEC_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [LVL_W-1:0]  lvl,
  input  logic              taken,
  input  logic              xfer_ack_n,
  input  logic [VEC_W-1:0]  rdata_lo,
  output logic [ADDR_W-1:0] addr,
  output logic              strobe_n,
  output logic              capture,
  output logic              valid,
  output logic [LVL_W-1:0]  cur_lvl,
  output logic [VEC_W-1:0]  vec_q
);
  ack_state_e st;
  logic       pending;
  logic       start;
  logic       in_cycle;

  assign start    = (st == ST_IDLE) && req && !pending;
  assign capture  = (st == ST_WAIT) && !xfer_ack_n;
  assign in_cycle = (st == ST_ADDR) || (st == ST_WAIT);
  assign strobe_n = (st != ST_WAIT);
  assign valid    = (st == ST_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      cur_lvl <= '0;
      vec_q   <= '0;
      pending <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (start) begin
          cur_lvl <= lvl;
          st      <= ST_ADDR;
        end
        ST_ADDR: st <= ST_WAIT;
        ST_WAIT: if (capture) begin
          vec_q <= rdata_lo;
          st    <= ST_DONE;
        end
        default: st <= ST_IDLE;
      endcase
      if (valid && !taken) pending <= 1'b1;
      else if (taken)      pending <= 1'b0;
    end
  end

  always_comb begin
    addr = '0;
    if (in_cycle) begin
      addr             = '1;
      addr[LVL_W-1:0]  = cur_lvl;
    end
  end

  AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe_n && xfer_ack_n) |=> !strobe_n); // R5
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid); // R7
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !taken && st == ST_IDLE) |=> (st == ST_IDLE)); // R8
  AST_ADDR_FORM: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe_n |-> ((addr[LVL_W-1:0] == cur_lvl) && (&addr[ADDR_W-1:LVL_W]))); // R3
endmodule

// File: rtl/intack_unit.sv
module intack_unit
  import intack_pkg::*;
#(
  parameter int ADDR_W = 23,
  parameter int DATA_W = 16,
  parameter int VEC_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        ipl_n,
  input  logic              mask_wr,
  input  logic [2:0]        mask_wdata,
  output logic [2:0]        mask_q,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              addr_strobe_n,
  output logic              upper_strobe_n,
  output logic              low_strobe_n,
  output logic              rd_wr,
  input  logic              xfer_ack_n,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              irq_valid,
  output logic [2:0]        irq_level,
  output logic [VEC_W-1:0]  irq_vector,
  input  logic              irq_taken
);
  logic [LVL_W-1:0] lvl_sync;
  logic             req;
  logic             capture;
  logic             strobe_n;
  logic             unused_hi;

  assign unused_hi = ^bus_rdata[DATA_W-1:VEC_W];

  ipl_sync #(.W(LVL_W)) u_sync (
    .clk(clk), .rst_n(rst_n), .ipl_n(ipl_n), .lvl(lvl_sync));

  irq_arbiter u_arb (
    .clk(clk), .rst_n(rst_n), .lvl(lvl_sync), .mask_wr(mask_wr),
    .mask_wdata(mask_wdata), .raise(capture), .raise_lvl(irq_level),
    .mask_q(mask_q), .req(req));

  ack_cycle #(.ADDR_W(ADDR_W), .VEC_W(VEC_W)) u_cyc (
    .clk(clk), .rst_n(rst_n), .req(req), .lvl(lvl_sync), .taken(irq_taken),
    .xfer_ack_n(xfer_ack_n), .rdata_lo(bus_rdata[VEC_W-1:0]),
    .addr(bus_addr), .strobe_n(strobe_n), .capture(capture),
    .valid(irq_valid), .cur_lvl(irq_level), .vec_q(irq_vector));

  assign addr_strobe_n  = strobe_n;
  assign low_strobe_n   = strobe_n;
  assign upper_strobe_n = 1'b1;
  assign rd_wr          = 1'b1;

  AST_LOW_LANE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_strobe_n |-> (rd_wr && !low_strobe_n && upper_strobe_n)); // R4
  AST_MASK_AT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> (mask_q == irq_level)); // R7
endmodule

// File: tb/tb_intack_unit.sv
module tb_intack_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  ipl_n = 3'b111;
  logic        mask_wr = 1'b0;
  logic [2:0]  mask_wdata = 3'd0;
  logic [2:0]  mask_q;
  logic [22:0] bus_addr;
  logic        addr_strobe_n, upper_strobe_n, low_strobe_n, rd_wr;
  logic        xfer_ack_n = 1'b1;
  logic [15:0] bus_rdata = 16'h0;
  logic        irq_valid;
  logic [2:0]  irq_level;
  logic [7:0]  irq_vector;
  logic        irq_taken = 1'b0;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  intack_unit dut (.*);

  // Bus responder state
  int          resp_waits = 0;
  logic [7:0]  resp_vec = 8'h0;
  int          scnt = 0;
  int          strobe_total = 0;
  logic [22:0] last_addr = '0;
  logic        lane_ok = 1'b1;

  function automatic logic exp_accept(input logic [2:0] l, input logic [2:0] m);
    if (l == 3'd0) return 1'b0;
    if (l == 3'd7) return 1'b1;
    return l > m;
  endfunction

  function automatic logic [22:0] exp_addr(input logic [2:0] l);
    return {20'hFFFFF, l};
  endfunction

  task automatic chk(input logic ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!addr_strobe_n) begin
      scnt++;
      strobe_total++;
      last_addr = bus_addr;
      if (!(rd_wr && !low_strobe_n && upper_strobe_n)) lane_ok = 1'b0;
      if (scnt > resp_waits) begin
        xfer_ack_n = 1'b0;
        bus_rdata  = {~resp_vec, resp_vec};
      end
    end else begin
      scnt = 0;
      xfer_ack_n = 1'b1;
    end
  end

  task automatic set_mask(input logic [2:0] m);
    @(negedge clk); mask_wr = 1'b1; mask_wdata = m;
    @(negedge clk); mask_wr = 1'b0;
    chk(mask_q == m, "R9 mask write", 32'(mask_q), 32'(m));
  endtask

  task automatic release_and_take();
    ipl_n = 3'b111;
    repeat (6) @(negedge clk);
    irq_taken = 1'b1;
    @(negedge clk);
    irq_taken = 1'b0;
  endtask

  task automatic run_case(input logic [2:0] l, input logic [2:0] m, input int w,
                          input logic [7:0] v);
    logic got;
    logic [2:0] glvl, gmask;
    logic [7:0] gvec;
    int i;
    set_mask(m);
    resp_waits = w; resp_vec = v; strobe_total = 0; lane_ok = 1'b1;
    got = 1'b0; glvl = '0; gmask = '0; gvec = '0; i = 0;
    ipl_n = ~l;
    while (!got && i < 40) begin
      @(negedge clk);
      i++;
      if (irq_valid) begin
        got = 1'b1; glvl = irq_level; gvec = irq_vector; gmask = mask_q;
      end
    end
    if (exp_accept(l, m)) begin
      chk(got, "R2 accepted request", 32'(got), 32'd1);
      chk(glvl == l, "R7 level", 32'(glvl), 32'(l));
      chk(gvec == v, "R4 vector low byte", 32'(gvec), 32'(v));
      chk(gmask == l, "R7 mask raised", 32'(gmask), 32'(l));
      chk(last_addr == exp_addr(l), "R3 address", 32'(last_addr), 32'(exp_addr(l)));
      chk(strobe_total == w + 1, "R5 wait states", 32'(strobe_total), 32'(w + 1));
      chk(lane_ok, "R4 lower lane read", 32'(lane_ok), 32'd1);
      @(negedge clk);
      chk(!irq_valid, "R7 single pulse", 32'(irq_valid), 32'd0);
    end else begin
      chk(!got && strobe_total == 0, "R2 rejected request",
          32'(strobe_total), 32'd0);
    end
    release_and_take();
  endtask

  initial begin
    void'($urandom(32'd421));
    repeat (3) @(negedge clk);
    chk(addr_strobe_n && low_strobe_n && upper_strobe_n, "R1 strobes idle",
        32'({addr_strobe_n, low_strobe_n, upper_strobe_n}), 32'h7);
    chk(!irq_valid, "R1 valid low", 32'(irq_valid), 32'd0);
    chk(mask_q == 3'd7, "R1 mask reset", 32'(mask_q), 32'd7);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // Directed corners
    run_case(3'd7, 3'd7, 0, 8'h5A);  // R2 top level beats full mask
    run_case(3'd6, 3'd7, 0, 8'h11);  // R2 masked
    run_case(3'd0, 3'd0, 0, 8'h22);  // R2 level 0 no request
    run_case(3'd4, 3'd4, 1, 8'h33);  // R2 equal to mask rejected
    run_case(3'd5, 3'd4, 3, 8'hC3);  // R5 three wait states

    // R6: one-cycle glitch ignored
    set_mask(3'd0);
    strobe_total = 0;
    @(negedge clk); ipl_n = ~3'd3;
    @(negedge clk); ipl_n = 3'b111;
    repeat (20) @(negedge clk);
    chk(strobe_total == 0, "R6 glitch ignored", 32'(strobe_total), 32'd0);

    // R8: no new cycle until taken
    begin
      int i;
      logic got;
      resp_waits = 0; resp_vec = 8'h77; strobe_total = 0;
      ipl_n = ~3'd2;
      got = 1'b0; i = 0;
      while (!got && i < 40) begin @(negedge clk); i++; got = irq_valid; end
      chk(got, "R8 first cycle", 32'(got), 32'd1);
      ipl_n = ~3'd5;
      strobe_total = 0;
      repeat (20) @(negedge clk);
      chk(strobe_total == 0, "R8 held off", 32'(strobe_total), 32'd0);
      irq_taken = 1'b1; @(negedge clk); irq_taken = 1'b0;
      got = 1'b0; i = 0;
      while (!got && i < 40) begin @(negedge clk); i++; got = irq_valid; end
      chk(got && irq_level == 3'd5, "R8 resumes after taken", 32'(irq_level), 32'd5);
      release_and_take();
    end

    // Constrained random
    for (int k = 0; k < 40; k++) begin
      run_case(3'($urandom_range(0, 7)), 3'($urandom_range(0, 7)),
               int'($urandom_range(0, 4)), 8'($urandom));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule